// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a memory-mapped watchdog timer. Its register port is single-cycle: one address, a write strobe, write data and registered read data. A 32-bit down-counter runs from a programmable reload value. When it first reaches zero, the block raises an interrupt flag and starts the count again. If software has not cleared the flag by the next time the counter reaches zero, and the reset function is enabled, the block raises a system reset request. That request stays high until the block itself is reset.

Software keeps the watchdog alive by writing the clear register. That write drops the interrupt flag and restarts the count. A lock register guards every other writable register. Writing one fixed key value opens the lock, and writing any other value closes it. Software can trigger an immediate restart by loading a count of zero and setting both enable bits.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset the block is unlocked, the reload register reads 0xFFFFFFFF, the control register reads 0, both status registers read 0, and `irq_o` and `sys_rst_o` are low.
- R2: The lock register sits at offset 0xC00. Writing 0x1ACCE551 to it unlocks the block, and writing any other value locks it. Reading it returns 1 when locked and 0 when unlocked.
- R3: While the block is locked, writes to the reload (0x000), control (0x008) and clear (0x00C) registers have no effect.
- R4: The counter (read at 0x004) decrements by one each cycle only while control bit 0 is set. With bit 0 clear it holds its value.
- R5: When the counter is at zero, bit 0 is set and the flag is clear, the next cycle sets the raw flag and reloads the counter. One stage therefore lasts reload+1 cycles.
- R6: When the counter is at zero with the flag already set and control bit 1 set, `sys_rst_o` rises and stays high until `rst` is applied. With bit 1 clear, the counter only reloads.
- R7: Any write to the clear register (0x00C) clears the raw flag and reloads the counter from the reload register.
- R8: A write to the reload register (0x000) loads the new value into the counter on the same edge.
- R9: Raw status (0x010) bit 0 is the flag. Masked status (0x014) bit 0 is the flag ANDed with control bit 0, and `irq_o` equals that masked bit. Control (0x008) reads back bits 1:0, and its other bits read 0.
- R10: With a reload value of 0 and both control bits set, `sys_rst_o` rises no more than 3 cycles after the control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Register byte offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data for the previous cycle's address |
| irq_o | output | 1 | Interrupt, the masked status bit |
| sys_rst_o | output | 1 | Sticky system reset request |

## Verification
On every cycle, the assertions check the counter's step and freeze rules, the reload on the first expiry, the stickiness of the reset request, and that clear and reload writes take effect. They also check that a locked block keeps its reload and control registers unchanged. Some behaviour can only be shown by the bench's scenarios: the full stage length, the point at which an unserviced second expiry turns into a reset, the readback encodings, and the immediate-restart path. In those scenarios, a cycle-level reference model is compared with the read data and both outputs on every clock.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [11:0] OFF_RELOAD = 12'h000;
  localparam logic [11:0] OFF_COUNT  = 12'h004;
  localparam logic [11:0] OFF_CTRL   = 12'h008;
  localparam logic [11:0] OFF_CLEAR  = 12'h00C;
  localparam logic [11:0] OFF_RAW    = 12'h010;
  localparam logic [11:0] OFF_MASKED = 12'h014;
  localparam logic [11:0] OFF_GUARD  = 12'hC00;
  localparam logic [31:0] GUARD_KEY  = 32'h1ACCE551;

  typedef struct packed {
    logic arm_rst;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs import wdog_pkg::*; #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] RELOAD_INIT = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] count,
  input  logic              flag,
  output logic [DATA_W-1:0] reload_q,
  output ctrl_t             ctrl_q,
  output logic              wr_reload,
  output logic              wr_clear,
  output logic [DATA_W-1:0] rd_data
);
  localparam int PAD_W = DATA_W - 2;

  logic              guard_q;
  logic              wr_open;
  logic [DATA_W-1:0] rd_nxt;

  assign wr_open   = wr_en && !guard_q;
  assign wr_reload = wr_open && (addr == ADDR_W'(OFF_RELOAD));
  assign wr_clear  = wr_open && (addr == ADDR_W'(OFF_CLEAR));

  always_comb begin
    rd_nxt = '0;
    case (addr)
      ADDR_W'(OFF_RELOAD): rd_nxt = reload_q;
      ADDR_W'(OFF_COUNT):  rd_nxt = count;
      ADDR_W'(OFF_CTRL):   rd_nxt = {{PAD_W{1'b0}}, ctrl_q.arm_rst, ctrl_q.run};
      ADDR_W'(OFF_RAW):    rd_nxt = DATA_W'(flag);
      ADDR_W'(OFF_MASKED): rd_nxt = DATA_W'(flag && ctrl_q.run);
      ADDR_W'(OFF_GUARD):  rd_nxt = DATA_W'(guard_q);
      default:             rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      guard_q  <= 1'b0;
      reload_q <= RELOAD_INIT;
      ctrl_q   <= '0;
      rd_data  <= '0;
    end else begin
      rd_data <= rd_nxt;
      if (wr_en && addr == ADDR_W'(OFF_GUARD))
        guard_q <= (wr_data != DATA_W'(GUARD_KEY));
      if (wr_reload)
        reload_q <= wr_data;
      if (wr_open && addr == ADDR_W'(OFF_CTRL))
        ctrl_q <= ctrl_t'(wr_data[1:0]);
    end
  end

  assert_locked_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (guard_q && wr_en && addr != ADDR_W'(OFF_GUARD)) |=> ($stable(reload_q) && $stable(ctrl_q)));

  assert_guard_key_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFF_GUARD)) |=> (guard_q == ($past(wr_data) != DATA_W'(GUARD_KEY))));
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] RELOAD_INIT = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              arm_rst,
  input  logic              wr_reload,
  input  logic              wr_clear,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] reload_q,
  output logic [DATA_W-1:0] count,
  output logic              flag,
  output logic              sys_rst
);
  logic at_zero;
  assign at_zero = (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= RELOAD_INIT;
      flag    <= 1'b0;
      sys_rst <= 1'b0;
    end else if (wr_reload) begin
      count <= wr_data;
    end else if (wr_clear) begin
      count <= reload_q;
      flag  <= 1'b0;
    end else if (run) begin
      if (at_zero) begin
        count <= reload_q;
        if (!flag)
          flag <= 1'b1;
        else if (arm_rst)
          sys_rst <= 1'b1;
      end else begin
        count <= count - 1'b1;
      end
    end
  end

  assert_step_R4: assert property (@(posedge clk) disable iff (rst)
    (run && !at_zero && !wr_reload && !wr_clear) |=> (count == $past(count) - 1'b1));

  assert_freeze_R4: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_reload && !wr_clear) |=> $stable(count));

  assert_first_expiry_R5: assert property (@(posedge clk) disable iff (rst)
    (run && at_zero && !flag && !wr_reload && !wr_clear) |=> (flag && count == $past(reload_q)));

  assert_rst_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    sys_rst |=> sys_rst);

  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    wr_clear |=> (!flag && count == $past(reload_q)));

  assert_reload_R8: assert property (@(posedge clk) disable iff (rst)
    wr_reload |=> (count == $past(wr_data)));
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage import wdog_pkg::*; #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] RELOAD_INIT = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_o,
  output logic              sys_rst_o
);
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] reload_q;
  logic [DATA_W-1:0] count;
  logic              flag;
  logic              wr_reload;
  logic              wr_clear;

  wdog_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RELOAD_INIT(RELOAD_INIT)) u_regs (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .count(count), .flag(flag), .reload_q(reload_q), .ctrl_q(ctrl_q),
    .wr_reload(wr_reload), .wr_clear(wr_clear), .rd_data(rd_data)
  );

  wdog_core #(.DATA_W(DATA_W), .RELOAD_INIT(RELOAD_INIT)) u_core (
    .clk(clk), .rst(rst), .run(ctrl_q.run), .arm_rst(ctrl_q.arm_rst),
    .wr_reload(wr_reload), .wr_clear(wr_clear), .wr_data(wr_data),
    .reload_q(reload_q), .count(count), .flag(flag), .sys_rst(sys_rst_o)
  );

  assign irq_o = flag && ctrl_q.run;
endmodule

// File: tb/wdog_two_stage_tb.sv
module wdog_two_stage_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] addr = 12'h004;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq_o, sys_rst_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  wdog_two_stage u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq_o(irq_o), .sys_rst_o(sys_rst_o)
  );

  // behavioural reference model
  bit [31:0] m_reload, m_count, m_rd;
  bit        m_run, m_arm, m_flag, m_rst, m_lock;

  function automatic bit [31:0] m_read(input bit [11:0] a);
    case (a)
      12'h000: return m_reload;
      12'h004: return m_count;
      12'h008: return {30'd0, m_arm, m_run};
      12'h010: return {31'd0, m_flag};
      12'h014: return {31'd0, m_flag & m_run};
      12'hC00: return {31'd0, m_lock};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_reload = 32'hFFFF_FFFF; m_count = 32'hFFFF_FFFF; m_rd = 0;
      m_run = 0; m_arm = 0; m_flag = 0; m_rst = 0; m_lock = 0;
    end else begin
      bit open;
      m_rd = m_read(addr);
      open = wr_en && !m_lock;
      if (open && addr == 12'h000) m_count = wr_data;
      else if (open && addr == 12'h00C) begin m_count = m_reload; m_flag = 0; end
      else if (m_run) begin
        if (m_count == 0) begin
          m_count = m_reload;
          if (m_flag && m_arm) m_rst = 1;
          m_flag = 1;
        end else m_count = m_count - 1;
      end
      if (open && addr == 12'h000) m_reload = wr_data;
      if (open && addr == 12'h008) begin m_run = wr_data[0]; m_arm = wr_data[1]; end
      if (wr_en && addr == 12'hC00) m_lock = (wr_data != 32'h1ACCE551);
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check("R9 model rd_data", rd_data, m_rd);
      check("R9 model irq_o", {31'd0, irq_o}, {31'd0, m_flag & m_run});
      check("R6 model sys_rst_o", {31'd0, sys_rst_o}, {31'd0, m_rst});
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = 12'h004;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr = a;
    @(negedge clk);
    d = rd_data;
    addr = 12'h004;
  endtask

  function automatic logic [31:0] b2w(input logic b);
    return {31'd0, b};
  endfunction

  initial begin
    int n;
    logic [31:0] v, v2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    rd(12'hC00, v); check("R1 lock", v, 0);
    rd(12'h000, v); check("R1 reload", v, 32'hFFFF_FFFF);
    rd(12'h008, v); check("R1 ctrl", v, 0);
    rd(12'h010, v); check("R1 raw", v, 0);
    rd(12'h014, v); check("R1 masked", v, 0);
    check("R1 irq", b2w(irq_o), 0);
    check("R1 sys_rst", b2w(sys_rst_o), 0);

    // R8 reload write loads counter; R4 frozen while disabled
    wr(12'h000, 32'd5);
    rd(12'h004, v); check("R8 count after reload", v, 5);
    repeat (3) @(negedge clk);
    rd(12'h004, v); check("R4 frozen", v, 5);

    // R5 stage length
    wr(12'h008, 32'd1);
    n = 0;
    while (!irq_o && n < 50) begin @(negedge clk); n++; end
    check("R5 stage cycles", n, 6);
    rd(12'h010, v); check("R5 raw flag", v, 1);
    rd(12'h014, v); check("R9 masked", v, 1);
    rd(12'h008, v); check("R9 ctrl readback", v, 1);

    // R6 second expiry without reset enable: no reset
    repeat (14) @(negedge clk);
    check("R6 no reset when bit1 clear", b2w(sys_rst_o), 0);

    // R9 mask by bit 0
    wr(12'h008, 32'hFFFF_FFFC);
    rd(12'h008, v); check("R9 ctrl other bits zero", v, 0);
    rd(12'h010, v); check("R9 raw kept", v, 1);
    rd(12'h014, v); check("R9 masked off", v, 0);
    check("R9 irq masked", b2w(irq_o), 0);

    // R7 clear
    wr(12'h00C, 32'h0);
    rd(12'h004, v); check("R7 count reloaded", v, 5);
    rd(12'h010, v); check("R7 flag cleared", v, 0);

    // R8 reload while running
    wr(12'h008, 32'd1);
    wr(12'h000, 32'd9);
    rd(12'h004, v); check("R8 count = new reload", v, 9);
    rd(12'h004, v2); check("R4 decrement", v2, 8);

    // R2/R3 lock
    wr(12'hC00, 32'h1);
    rd(12'hC00, v); check("R2 locked reads 1", v, 1);
    wr(12'h000, 32'd3);
    rd(12'h000, v); check("R3 reload ignored", v, 9);
    wr(12'h008, 32'd3);
    rd(12'h008, v); check("R3 ctrl ignored", v, 1);
    n = 0;
    while (!irq_o && n < 50) begin @(negedge clk); n++; end
    wr(12'h00C, 32'h0);
    rd(12'h010, v); check("R3 clear ignored", v, 1);
    wr(12'hC00, 32'h1ACCE551);
    rd(12'hC00, v); check("R2 unlocked reads 0", v, 0);

    // R6 reset path and stickiness
    wr(12'h008, 32'd3);
    n = 0;
    while (!sys_rst_o && n < 60) begin @(negedge clk); n++; end
    check("R6 reset asserted", b2w(sys_rst_o), 1);
    wr(12'h00C, 32'h0);
    wr(12'h008, 32'd0);
    repeat (20) @(negedge clk);
    check("R6 reset sticky", b2w(sys_rst_o), 1);

    // R10 immediate restart
    rst = 1'b1; @(negedge clk); rst = 1'b0; @(negedge clk);
    check("R6 cleared by rst", b2w(sys_rst_o), 0);
    wr(12'h000, 32'd0);
    wr(12'h008, 32'd3);
    n = 0;
    while (!sys_rst_o && n < 10) begin @(negedge clk); n++; end
    check("R10 restart within 3 cycles", b2w(sys_rst_o && n <= 3), 1);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule